// File: doc/BRIEF.md
# Overhead Channel Capture with Loss Substitution

This block sits behind a receive framer that has already found the frame boundaries and picked the overhead bytes out of the stream. Each overhead byte arrives on one shared byte bus, together with a strobe that names its field: error-correction bytes, flow-control bytes, the remote alarm/signalling byte or the link label byte. The error-correction and flow-control strobes also carry a byte index. The block stores the bytes in held registers. It presents the current effective value of each field, along with a per-field valid indication.

A frame-delineated flag qualifies every capture. While the flag is low, no byte is written, every valid indication is low, and each field shows its substitute value. The flow-control field reads as all ones, which halts every port. The other fields freeze at the last value captured while delineation held. When delineation returns, each flow-control byte stays at all ones until a fresh byte is strobed into it.

The flow-control width is a parameter, with one bit per port. The number of error-correction bytes is also a parameter.

Top module: `ovh_capture`

## Requirements
- R1: After reset, the error-correction, alarm and label values read zero, the flow-control value reads all ones, and all four valid indications are low.
- R2: While `frm_locked` is high, a strobed byte appears on its field output one clock after the strobe. Error-correction byte index k lands in bits [8k+7:8k].
- R3: Strobes that arrive while `frm_locked` is low write nothing: the error-correction, alarm and label values stay unchanged.
- R4: From the clock after `frm_locked` is sampled low, the flow-control value reads all ones.
- R5: While delineation is lost, the error-correction, alarm and label values hold the last bytes captured while delineation held.
- R6: A field's valid indication is high only while delineation holds and every byte of that field has been written since delineation was last regained (or since reset). It drops one clock after `frm_locked` is sampled low.
- R7: After delineation is regained, each flow-control byte k (bits [8k+7:8k]) keeps reading all ones until its own strobe. A narrower top byte takes the low bits of the strobed byte.
- R8: An error-correction strobe whose index is not below `ECC_BYTES` changes no output.
- R9: When several field strobes coincide, each strobed field captures the same bus byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_locked | input | 1 | Frame delineation achieved |
| ovh_byte | input | 8 | Shared overhead byte bus |
| ecc_stb | input | 1 | Error-correction byte strobe |
| ecc_idx | input | ECC_IW | Error-correction byte index |
| fc_stb | input | 1 | Flow-control byte strobe |
| fc_idx | input | FC_IW | Flow-control byte index |
| alarm_stb | input | 1 | Remote alarm/signalling byte strobe |
| label_stb | input | 1 | Link label byte strobe |
| ecc_value | output | 8*ECC_BYTES | Effective error-correction bytes |
| ecc_vld | output | 1 | Error-correction field valid |
| fc_value | output | FC_BITS | Effective flow-control bits, one per port |
| fc_vld | output | 1 | Flow-control field valid |
| alarm_value | output | 8 | Effective alarm/signalling byte |
| alarm_vld | output | 1 | Alarm field valid |
| label_value | output | 8 | Effective link label byte |
| label_vld | output | 1 | Label field valid |

## Verification
The bench runs a configuration with three error-correction bytes and a 12-bit flow-control field. This covers an index beyond the last byte and a partial top byte, across all 256 byte values. It targets four corner cases:
- **Strobes during loss.** A design that let these through would corrupt the frozen values.
- **Regain.** A design that restored the old flow-control byte early would release halted ports on stale data.
- **Partial byte.** A design that sliced the wrong bits would misreport the upper ports.
- **Valid timing.** A design that raised valid after only one of several bytes would expose a half-written field.

// File: rtl/ovh_pkg.sv
package ovh_pkg;
  typedef enum logic {POL_FREEZE = 1'b0, POL_FORCE_ONES = 1'b1} loss_pol_e;

  function automatic int idx_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  function automatic int nbytes(input int bits);
    return (bits + 7) / 8;
  endfunction
endpackage

// File: rtl/ovh_byte_cell.sv
module ovh_byte_cell
  import ovh_pkg::*;
#(
  parameter int        BITS   = 8,
  parameter loss_pol_e POLICY = POL_FREEZE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            locked,
  input  logic            wr,
  input  logic [7:0]      din,
  output logic [BITS-1:0] q,
  output logic            fresh
);
  localparam logic [BITS-1:0] RST_VAL = (POLICY == POL_FORCE_ONES) ? '1 : '0;

  logic unused_din;
  assign unused_din = ^din;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= RST_VAL;
      fresh <= 1'b0;
    end else if (!locked) begin
      fresh <= 1'b0;
      if (POLICY == POL_FORCE_ONES) q <= '1;
    end else if (wr) begin
      q     <= din[BITS-1:0];
      fresh <= 1'b1;
    end
  end
endmodule

// File: rtl/ovh_field.sv
module ovh_field
  import ovh_pkg::*;
#(
  parameter int        NBYTES = 1,
  parameter int        WIDTH  = 8,
  parameter loss_pol_e POLICY = POL_FREEZE,
  localparam int       IW     = idx_w(NBYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             locked,
  input  logic             wr_stb,
  input  logic [IW-1:0]    wr_idx,
  input  logic [7:0]       din,
  output logic [WIDTH-1:0] value,
  output logic             vld
);
  logic [NBYTES-1:0] fresh;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int BW = ((WIDTH - 8*b) >= 8) ? 8 : (WIDTH - 8*b);
    logic hit;
    assign hit = wr_stb && (wr_idx == IW'(b));
    ovh_byte_cell #(.BITS(BW), .POLICY(POLICY)) u_cell (
      .clk(clk), .rst(rst), .locked(locked), .wr(hit), .din(din),
      .q(value[8*b +: BW]), .fresh(fresh[b])
    );
  end

  assign vld = &fresh;
endmodule

// File: rtl/ovh_capture.sv
module ovh_capture
  import ovh_pkg::*;
#(
  parameter int  ECC_BYTES = 2,
  parameter int  FC_BITS   = 16,
  localparam int ECC_IW    = idx_w(ECC_BYTES),
  localparam int FC_NB     = nbytes(FC_BITS),
  localparam int FC_IW     = idx_w(FC_NB)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frm_locked,
  input  logic [7:0]             ovh_byte,
  input  logic                   ecc_stb,
  input  logic [ECC_IW-1:0]      ecc_idx,
  input  logic                   fc_stb,
  input  logic [FC_IW-1:0]       fc_idx,
  input  logic                   alarm_stb,
  input  logic                   label_stb,
  output logic [8*ECC_BYTES-1:0] ecc_value,
  output logic                   ecc_vld,
  output logic [FC_BITS-1:0]     fc_value,
  output logic                   fc_vld,
  output logic [7:0]             alarm_value,
  output logic                   alarm_vld,
  output logic [7:0]             label_value,
  output logic                   label_vld
);
  ovh_field #(.NBYTES(ECC_BYTES), .WIDTH(8*ECC_BYTES), .POLICY(POL_FREEZE)) u_ecc (
    .clk(clk), .rst(rst), .locked(frm_locked), .wr_stb(ecc_stb), .wr_idx(ecc_idx),
    .din(ovh_byte), .value(ecc_value), .vld(ecc_vld)
  );

  ovh_field #(.NBYTES(FC_NB), .WIDTH(FC_BITS), .POLICY(POL_FORCE_ONES)) u_fc (
    .clk(clk), .rst(rst), .locked(frm_locked), .wr_stb(fc_stb), .wr_idx(fc_idx),
    .din(ovh_byte), .value(fc_value), .vld(fc_vld)
  );

  ovh_field #(.NBYTES(1), .WIDTH(8), .POLICY(POL_FREEZE)) u_alarm (
    .clk(clk), .rst(rst), .locked(frm_locked), .wr_stb(alarm_stb), .wr_idx(1'b0),
    .din(ovh_byte), .value(alarm_value), .vld(alarm_vld)
  );

  ovh_field #(.NBYTES(1), .WIDTH(8), .POLICY(POL_FREEZE)) u_label (
    .clk(clk), .rst(rst), .locked(frm_locked), .wr_stb(label_stb), .wr_idx(1'b0),
    .din(ovh_byte), .value(label_value), .vld(label_vld)
  );
endmodule

// File: rtl/ovh_capture_chk.sv
module ovh_capture_chk
  import ovh_pkg::*;
#(
  parameter int  ECC_BYTES = 2,
  parameter int  FC_BITS   = 16,
  localparam int ECC_IW    = idx_w(ECC_BYTES),
  localparam int FC_NB     = nbytes(FC_BITS),
  localparam int FC_IW     = idx_w(FC_NB)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   frm_locked,
  input logic [7:0]             ovh_byte,
  input logic                   ecc_stb,
  input logic [ECC_IW-1:0]      ecc_idx,
  input logic                   fc_stb,
  input logic [FC_IW-1:0]       fc_idx,
  input logic                   alarm_stb,
  input logic                   label_stb,
  input logic [8*ECC_BYTES-1:0] ecc_value,
  input logic                   ecc_vld,
  input logic [FC_BITS-1:0]     fc_value,
  input logic                   fc_vld,
  input logic [7:0]             alarm_value,
  input logic                   alarm_vld,
  input logic [7:0]             label_value,
  input logic                   label_vld
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (fc_value == '1 && ecc_value == '0 && alarm_value == 8'h00 &&
             label_value == 8'h00 && !ecc_vld && !fc_vld && !alarm_vld && !label_vld));

  assert_alarm_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (frm_locked && alarm_stb) |=> (alarm_value == $past(ovh_byte) && alarm_vld));

  assert_label_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (frm_locked && label_stb) |=> (label_value == $past(ovh_byte) && label_vld));

  assert_no_write_unlocked_R3: assert property (@(posedge clk) disable iff (rst)
    (!frm_locked && (ecc_stb || alarm_stb || label_stb)) |=>
      ($stable(ecc_value) && $stable(alarm_value) && $stable(label_value)));

  assert_fc_halt_R4: assert property (@(posedge clk) disable iff (rst)
    !frm_locked |=> fc_value == '1);

  assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    !frm_locked |=> ($stable(ecc_value) && $stable(alarm_value) && $stable(label_value)));

  assert_valid_drop_R6: assert property (@(posedge clk) disable iff (rst)
    !frm_locked |=> !(ecc_vld || fc_vld || alarm_vld || label_vld));

  assert_fc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (frm_locked && !fc_stb) |=> $stable(fc_value));

  assert_ecc_oob_R8: assert property (@(posedge clk) disable iff (rst)
    (frm_locked && ecc_stb && (int'(ecc_idx) >= ECC_BYTES)) |=> $stable(ecc_value));
endmodule

bind ovh_capture ovh_capture_chk #(.ECC_BYTES(ECC_BYTES), .FC_BITS(FC_BITS)) u_chk (.*);

// File: tb/tb_ovh_capture.sv
`timescale 1ns/1ps
module tb_ovh_capture;
  localparam int ECC_BYTES = 3;
  localparam int FC_BITS   = 12;
  localparam int ECC_IW    = 2;
  localparam int FC_IW     = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_locked = 1'b0;
  logic [7:0] ovh_byte = '0;
  logic ecc_stb = 1'b0, fc_stb = 1'b0, alarm_stb = 1'b0, label_stb = 1'b0;
  logic [ECC_IW-1:0] ecc_idx = '0;
  logic [FC_IW-1:0]  fc_idx = '0;
  logic [8*ECC_BYTES-1:0] ecc_value;
  logic [FC_BITS-1:0] fc_value;
  logic [7:0] alarm_value, label_value;
  logic ecc_vld, fc_vld, alarm_vld, label_vld;

  always #4 clk = ~clk;

  ovh_capture #(.ECC_BYTES(ECC_BYTES), .FC_BITS(FC_BITS)) dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model, derived from the requirements
  logic [7:0] m_ecc [ECC_BYTES];
  logic [ECC_BYTES-1:0] m_ecc_new;
  logic [7:0] m_fc [2];
  logic [1:0] m_fc_new;
  logic [7:0] m_alarm, m_label;
  logic m_alarm_new, m_label_new;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    logic [8*ECC_BYTES-1:0] e;
    logic [FC_BITS-1:0] f;
    for (int k = 0; k < ECC_BYTES; k++) e[8*k +: 8] = m_ecc[k];
    f[7:0]  = m_fc[0];
    f[11:8] = m_fc[1][3:0];
    chk(tag, "ecc_value",   32'(ecc_value),   32'(e));
    chk(tag, "fc_value",    32'(fc_value),    32'(f));
    chk(tag, "alarm_value", 32'(alarm_value), 32'(m_alarm));
    chk(tag, "label_value", 32'(label_value), 32'(m_label));
    chk(tag, "ecc_vld",   32'(ecc_vld),   32'(&m_ecc_new));
    chk(tag, "fc_vld",    32'(fc_vld),    32'(&m_fc_new));
    chk(tag, "alarm_vld", 32'(alarm_vld), 32'(m_alarm_new));
    chk(tag, "label_vld", 32'(label_vld), 32'(m_label_new));
  endtask

  task automatic model_reset();
    for (int k = 0; k < ECC_BYTES; k++) m_ecc[k] = 8'h00;
    m_ecc_new = '0;
    m_fc[0] = 8'hFF; m_fc[1] = 8'hFF; m_fc_new = '0;
    m_alarm = 8'h00; m_label = 8'h00;
    m_alarm_new = 1'b0; m_label_new = 1'b0;
  endtask

  // drive away from the edge, clock once, update model, sample after the edge
  task automatic step(input string tag, input logic lk, input logic [7:0] b,
                      input logic es, input int ei, input logic fs, input int fi,
                      input logic as, input logic ls);
    @(negedge clk);
    frm_locked = lk; ovh_byte = b;
    ecc_stb = es; ecc_idx = ECC_IW'(ei); fc_stb = fs; fc_idx = FC_IW'(fi);
    alarm_stb = as; label_stb = ls;
    @(posedge clk);
    if (!lk) begin
      m_ecc_new = '0; m_fc_new = '0; m_alarm_new = 0; m_label_new = 0;
      m_fc[0] = 8'hFF; m_fc[1] = 8'hFF;
    end else begin
      if (es && ei < ECC_BYTES) begin m_ecc[ei] = b; m_ecc_new[ei] = 1'b1; end
      if (fs) begin
        m_fc[fi] = (fi == 1) ? {4'hF, b[3:0]} : b;
        m_fc_new[fi] = 1'b1;
      end
      if (as) begin m_alarm = b; m_alarm_new = 1'b1; end
      if (ls) begin m_label = b; m_label_new = 1'b1; end
    end
    #1;
    compare(tag);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    @(negedge clk); rst = 1'b0;
    #1;
    compare("R1");

    // R2 / R8: all byte values through every field and index, including idx 3
    for (int v = 0; v < 256; v++) begin
      step("R2", 1, 8'(v), 1, v % 4, 0, 0, 0, 0);
      step("R8", 1, 8'(v ^ 8'h5A), 1, 3, 0, 0, 0, 0);
      step("R7", 1, 8'(v + 3), 0, 0, 1, v % 2, 0, 0);
      step("R2", 1, 8'(~v), 0, 0, 0, 0, v[0], ~v[0]);
    end

    // R9: coincident strobes
    for (int v = 0; v < 8; v++)
      step("R9", 1, 8'(8'h90 + v), 1, v % 3, 1, v % 2, 1, 1);

    // R4 / R3 / R5: loss with and without strobes
    step("R4", 0, 8'h11, 0, 0, 0, 0, 0, 0);
    for (int v = 0; v < 64; v++)
      step("R3", 0, 8'(v * 7), 1, v % 4, 1, v % 2, v[0], v[1]);
    for (int v = 0; v < 8; v++)
      step("R5", 0, 8'hEE, 0, 0, 0, 0, 0, 0);

    // R7 / R6: regain, flow control waits for each byte
    for (int v = 0; v < 4; v++) step("R7", 1, 8'h00, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 8'h3C, 0, 0, 1, 0, 0, 0);
    step("R7", 1, 8'h00, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 8'hA5, 0, 0, 1, 1, 0, 0);
    step("R6", 1, 8'h01, 1, 0, 0, 0, 0, 0);
    step("R6", 1, 8'h02, 1, 1, 0, 0, 0, 0);
    step("R6", 1, 8'h03, 1, 2, 0, 0, 0, 0);

    // R6: pseudo-random mix of lock changes and strobes
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R6", (lfsr[3:0] != 0), lfsr[15:8], lfsr[4], int'(lfsr[6:5]),
           lfsr[7], int'(lfsr[8]), lfsr[9], lfsr[10]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule